// File: doc/BRIEF.md
# Configuration Stream Header Stripper

The block sits on a byte stream that carries a programmable-logic configuration file and hands on only the configuration payload. It throws away a fixed-size prefix, walks across a run of four text fields whose sizes come from the stream itself, and then looks for the synchronisation preamble. Everything after the preamble goes out of the block unchanged.

The `long_sync` input picks the preamble format. With `long_sync` low the preamble is two bytes: 0xFF, then any byte whose upper nibble is 0x3. Both of these bytes are dropped. With `long_sync` high the preamble is four 0xFF bytes in a row, and these bytes are part of the forwarded payload. A one-cycle `sof` pulse puts the block back at the start of a new file. `found` tells the consumer that payload has begun to arrive.

Both stream sides use a valid/ready handshake and move one byte per beat. The output is registered. When the consumer holds off, the input is held off in turn.

Top module: `cfg_stream_stripper`

## Requirements
- R1: The first 15 bytes after reset or `sof` (positions 0 to 14) are dropped whatever their values, even a 0xFF followed by 0x3X.
- R2: From position 15 there are four fields. The first byte of each field holds a length L, and the whole field is L+3 bytes counted from that length byte. L can be any value from 0 to 255. Every byte of these fields is dropped, even bytes that look like a preamble.
- R3: With `long_sync`=0 the preamble is a byte 0xFF followed by a byte with bits [7:4] = 4'h3. Neither byte is forwarded, and the first output byte is the byte after them. If the preamble never appears, nothing is output.
- R4: With `long_sync`=0, a 0xFF followed by a byte that does not match is still a candidate first byte, so FF FF 3X is found as a preamble.
- R5: With `long_sync`=1 the preamble is four consecutive 0xFF bytes. Output starts with the first of those four. A fifth 0xFF or any later byte is forwarded in turn.
- R6: With `long_sync`=1 a byte other than 0xFF breaks the run of 0xFF, so FF FF FF 00 does not start the payload.
- R7: After the preamble, every input byte is forwarded once, in order and unchanged, including bytes that look like a preamble.
- R8: `found` goes high in the cycle the first payload byte appears on `out_valid`. It stays high until `sof` or `rst`, and it stays low for a file that has no preamble.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` stays the same. When the output stalls, the input is stalled, and no byte is lost or duplicated.
- R10: A `sof` pulse clears `out_valid` and `found`, drops any partial header or payload state, and holds `in_ready` low for that cycle. The next byte accepted is position 0 of a new file.
- R11: After `rst`, `out_valid`=0, `found`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-file restart pulse |
| long_sync | input | 1 | 0: two-byte preamble, dropped; 1: four-byte 0xFF preamble, forwarded |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output payload byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| found | output | 1 | Payload has started in this file |

## Verification
The prefix and the field bodies are loaded with bytes that look like preambles. A walker that miscounts a field length, mishandles L=0 or L=255, or starts searching too early locks onto one of these bytes and sends header junk downstream. False starts come just before the real preamble: FF FF 3X in short mode, and FF FF FF 00 followed by a run of five 0xFF in long mode. A matcher that drops the candidate after a mismatch misses the preamble, and one that counts across a break starts too soon. Heavy output stalls during the long-mode replay catch dropped or repeated 0xFF bytes. A `sof` in the middle of a payload, and a file that never has a preamble, show whether `found` is cleared on `sof` and whether it is raised without cause.

// File: rtl/strip_pkg.sv
package strip_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_SYNC = 2'd1,
    PH_FILL = 2'd2,
    PH_PASS = 2'd3
  } phase_t;

  localparam logic [7:0] SYNC_BYTE   = 8'hFF;
  localparam logic [3:0] SHORT_NIB   = 4'h3;

endpackage

// File: rtl/strip_hdr_walker.sv
module strip_hdr_walker #(
  parameter int DW         = 8,
  parameter int PREFIX_LEN = 15,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_XTRA = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] data,
  output logic          last
);
  localparam int PW = $clog2(PREFIX_LEN + 2);
  localparam int RW = DW + 1;
  localparam int FW = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;

  logic [PW-1:0] pre_cnt;
  logic          pre_done;
  logic          in_body;
  logic [RW-1:0] rem;
  logic [FW-1:0] fld;

  assign pre_done = (pre_cnt == PW'(PREFIX_LEN));
  assign last     = take && pre_done && in_body && (rem == RW'(1)) &&
                    (fld == FW'(NUM_FIELDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      in_body <= 1'b0;
      rem     <= '0;
      fld     <= '0;
    end else if (take) begin
      if (!pre_done) begin
        pre_cnt <= pre_cnt + PW'(1);
      end else if (!in_body) begin
        rem     <= {1'b0, data} + RW'(FIELD_XTRA);
        in_body <= 1'b1;
      end else begin
        rem <= rem - RW'(1);
        if (rem == RW'(1)) begin
          in_body <= 1'b0;
          fld     <= fld + FW'(1);
        end
      end
    end
  end

  AST_PREFIX_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PW'(PREFIX_LEN)) else $error("prefix counter overrun"); // R1

  AST_BODY_NONZERO: assert property (@(posedge clk) disable iff (rst)
    in_body |-> rem != '0) else $error("field body with zero remaining"); // R2

endmodule

// File: rtl/strip_sync_finder.sv
module strip_sync_finder
  import strip_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LONG_RUN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] data,
  input  logic          long_mode,
  output logic          hit
);
  localparam int RUNW = $clog2(LONG_RUN + 1);
  localparam logic [RUNW-1:0] RUN_TOP = RUNW'(LONG_RUN - 1);

  logic [RUNW-1:0] run;
  logic            is_ff;
  logic            short_hit;
  logic            long_hit;

  assign is_ff     = (data == SYNC_BYTE);
  assign short_hit = (run != '0) && (data[DW-1:DW-4] == SHORT_NIB);
  assign long_hit  = is_ff && (run == RUN_TOP);
  assign hit       = take && (long_mode ? long_hit : short_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (take) begin
      if (!is_ff)               run <= '0;
      else if (run != RUN_TOP)  run <= run + RUNW'(1);
    end
  end

  AST_RUN_CAP: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_TOP) else $error("0xFF run counter beyond cap"); // R5

  AST_RUN_BREAK: assert property (@(posedge clk) disable iff (rst)
    take && !is_ff |=> run == '0) else $error("run survived non-FF byte"); // R6

endmodule

// File: rtl/strip_out_stage.sv
module strip_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          ready_dn,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          free
);
  assign free = !valid || ready_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready_dn) begin
      valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid && !ready_dn |=> valid && $stable(dout)) else $error("output changed while stalled"); // R9

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load |-> free) else $error("load into occupied output slot"); // R9

endmodule

// File: rtl/cfg_stream_stripper.sv
module cfg_stream_stripper
  import strip_pkg::*;
#(
  parameter int DW         = 8,
  parameter int PREFIX_LEN = 15,
  parameter int NUM_FIELDS = 4,
  parameter int LONG_RUN   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sof,
  input  logic          long_sync,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          found
);
  localparam int FCW = $clog2(LONG_RUN + 1);

  phase_t         phase;
  logic [FCW-1:0] fill_left;
  logic           clr;
  logic           acc;
  logic           slot_free;
  logic           load;
  logic [DW-1:0]  load_data;
  logic           hdr_last;
  logic           sync_hit;

  assign clr = rst || sof;

  always_comb begin
    in_ready = 1'b0;
    if (!sof) begin
      case (phase)
        PH_HDR, PH_SYNC: in_ready = 1'b1;
        PH_PASS:         in_ready = slot_free;
        default:         in_ready = 1'b0;
      endcase
    end
  end

  assign acc       = in_valid && in_ready;
  assign load      = ((phase == PH_FILL) && slot_free) || ((phase == PH_PASS) && acc);
  assign load_data = (phase == PH_FILL) ? SYNC_BYTE : in_data;

  strip_hdr_walker #(
    .DW(DW), .PREFIX_LEN(PREFIX_LEN), .NUM_FIELDS(NUM_FIELDS), .FIELD_XTRA(2)
  ) u_walker (
    .clk(clk), .rst(clr), .take(acc && (phase == PH_HDR)),
    .data(in_data), .last(hdr_last)
  );

  strip_sync_finder #(
    .DW(DW), .LONG_RUN(LONG_RUN)
  ) u_finder (
    .clk(clk), .rst(clr), .take(acc && (phase == PH_SYNC)),
    .data(in_data), .long_mode(long_sync), .hit(sync_hit)
  );

  strip_out_stage #(
    .DW(DW)
  ) u_out (
    .clk(clk), .rst(clr), .load(load), .din(load_data), .ready_dn(out_ready),
    .valid(out_valid), .dout(out_data), .free(slot_free)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      phase     <= PH_HDR;
      fill_left <= '0;
      found     <= 1'b0;
    end else begin
      if (load) found <= 1'b1;
      case (phase)
        PH_HDR: if (hdr_last) phase <= PH_SYNC;
        PH_SYNC: begin
          if (sync_hit) begin
            if (long_sync) begin
              phase     <= PH_FILL;
              fill_left <= FCW'(LONG_RUN);
            end else begin
              phase <= PH_PASS;
            end
          end
        end
        PH_FILL: begin
          if (slot_free) begin
            fill_left <= fill_left - FCW'(1);
            if (fill_left == FCW'(1)) phase <= PH_PASS;
          end
        end
        default: ;
      endcase
    end
  end

  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (clr)
    phase == PH_HDR |-> !out_valid) else $error("output during header"); // R1

  AST_FOUND_STICKY: assert property (@(posedge clk) disable iff (clr)
    found |=> found) else $error("found dropped without restart"); // R8

  AST_FOUND_WITH_DATA: assert property (@(posedge clk) disable iff (clr)
    out_valid |-> found) else $error("payload shown without found"); // R8

  AST_FILL_STALL: assert property (@(posedge clk) disable iff (clr)
    phase == PH_FILL |-> !in_ready) else $error("input taken during preamble replay"); // R9

  AST_SOF_BLOCK: assert property (@(posedge clk) disable iff (rst)
    sof |-> !in_ready) else $error("input taken during restart"); // R10

endmodule

// File: tb/sim_cfg_stream_stripper.sv
`timescale 1ns/1ps
module sim_cfg_stream_stripper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0;
  logic       long_sync = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;
  logic       found;

  always #5 clk = ~clk;

  cfg_stream_stripper u0 (
    .clk(clk), .rst(rst), .sof(sof), .long_sync(long_sync),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .found(found)
  );

  int total = 0;
  int bad = 0;
  int got = 0;
  int exp_n = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit stall_en = 1'b0;
  bit hold_prev = 1'b0;
  logic [7:0] prev_data = 8'h00;
  logic [7:0] lf = 8'hA5;
  logic [7:0] file_q[$];
  logic [7:0] exp_q[$];
  string cur_tag = "R7";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // reference: where the payload starts, computed from the file layout
  task automatic build_expected(input bit lmode);
    int idx;
    int start;
    idx = 15;
    for (int f = 0; f < 4; f++) idx += int'(file_q[idx]) + 3;
    start = file_q.size();
    if (!lmode) begin
      for (int i = idx; i + 1 < file_q.size(); i++)
        if (file_q[i] == 8'hFF && file_q[i+1][7:4] == 4'h3) begin start = i + 2; break; end
    end else begin
      for (int i = idx; i + 3 < file_q.size(); i++)
        if (file_q[i] == 8'hFF && file_q[i+1] == 8'hFF &&
            file_q[i+2] == 8'hFF && file_q[i+3] == 8'hFF) begin start = i; break; end
    end
    exp_q.delete();
    for (int i = start; i < file_q.size(); i++) exp_q.push_back(file_q[i]);
    exp_n = exp_q.size();
  endtask

  task automatic add_hdr(input int l0, input int l1, input int l2, input int l3);
    int ls[4];
    ls = '{l0, l1, l2, l3};
    file_q.delete();
    for (int i = 0; i < 15; i++)
      file_q.push_back(i == 3 ? 8'hFF : i == 4 ? 8'h35 : i == 8 ? 8'hFF : 8'(i * 7 + 1));
    for (int f = 0; f < 4; f++) begin
      file_q.push_back(8'(ls[f]));
      for (int k = 0; k < ls[f] + 2; k++)
        file_q.push_back(k < 4 ? 8'hFF : k == 4 ? 8'h3A : 8'(k * 3));
    end
  endtask

  task automatic add_bytes(input logic [7:0] b[$]);
    foreach (b[i]) file_q.push_back(b[i]);
  endtask

  task automatic add_payload(input int n, input int seed);
    for (int k = 0; k < n; k++) file_q.push_back(8'(k * 13 + seed));
  endtask

  // called at posedge+1
  task automatic run_file(input bit lmode, input string tag, input int limit, input bit stall);
    int n;
    bit ok;
    stall_en = stall;
    cur_tag = tag;
    sof = 1'b1;
    long_sync = lmode;
    build_expected(lmode);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10", int'(in_ready), 0);
    @(posedge clk); #1;
    sof = 1'b0;
    got = 0;
    hold_prev = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
    chk(found == 1'b0, "R10", int'(found), 0);
    @(posedge clk); #1;
    n = (limit < 0) ? file_q.size() : limit;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = file_q[i];
      ok = 1'b0;
      while (!ok) begin
        @(negedge clk);
        ok = in_ready;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    if (limit < 0) begin
      for (int w = 0; w < 3000; w++) begin
        @(negedge clk);
        if (exp_q.size() == 0) break;
      end
      repeat (4) @(negedge clk);
      chk(got == exp_n, tag, got, exp_n);
      chk(found == (exp_n > 0), "R8", int'(found), int'(exp_n > 0));
      @(posedge clk); #1;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (stall_en) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = lf[0] | lf[2];
    end else begin
      out_ready = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (mon_en && !rst && !sof) begin
      if (hold_prev)
        chk(out_valid && out_data == prev_data, "R9", int'(out_data), int'(prev_data));
      hold_prev = out_valid && !out_ready;
      prev_data = out_data;
      chk(found == (out_valid || got > 0), "R8", int'(found), int'(out_valid || got > 0));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, int'(out_data), -1);
        end else begin
          chk(out_data == exp_q[0], cur_tag, int'(out_data), int'(exp_q[0]));
          void'(exp_q.pop_front());
        end
        got++;
      end
    end else begin
      hold_prev = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", int'(out_valid), 0);
    chk(found == 1'b0, "R11", int'(found), 0);
    chk(in_ready == 1'b1, "R11", int'(in_ready), 1);
    mon_en = 1'b1;
    @(posedge clk); #1;

    // short preamble after a false start, trap bytes in prefix and fields
    add_hdr(0, 3, 1, 2);
    add_bytes('{8'h12, 8'hFF, 8'h12, 8'h00, 8'hFF, 8'hFF, 8'h31});
    add_payload(5, 5);
    add_bytes('{8'hFF, 8'h35, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
    add_payload(20, 9);
    run_file(1'b0, "R1/R2/R3/R4/R7", -1, 1'b0);

    // long preamble after a broken run, output stalled
    add_hdr(5, 0, 9, 1);
    add_bytes('{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h11, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA});
    add_payload(10, 3);
    add_bytes('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h30});
    add_payload(15, 7);
    run_file(1'b1, "R5/R6/R7/R9", -1, 1'b1);

    // extreme field lengths, preamble right after the fields, stalled
    add_hdr(255, 0, 200, 7);
    add_bytes('{8'hFF, 8'h3F});
    add_payload(40, 1);
    run_file(1'b0, "R2/R3/R9", -1, 1'b1);

    // restart in the middle of a payload
    add_hdr(1, 1, 1, 1);
    add_bytes('{8'hFF, 8'hFF, 8'hFF, 8'hFF});
    add_payload(30, 2);
    run_file(1'b1, "R10", 15 + 4 * 4 + 4 + 10, 1'b0);
    add_hdr(2, 2, 2, 2);
    add_bytes('{8'hFF, 8'h30});
    add_payload(10, 4);
    run_file(1'b0, "R10/R3", -1, 1'b0);

    // no preamble at all: nothing out, found stays low
    add_hdr(1, 2, 3, 4);
    add_bytes('{8'h00, 8'hFF, 8'h40, 8'hFF, 8'h2F, 8'h11, 8'hFF});
    run_file(1'b0, "R3/R8", -1, 1'b0);

    // same idea in long mode: runs of three only
    add_hdr(6, 6, 6, 6);
    add_bytes('{8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF});
    run_file(1'b1, "R6/R8", -1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule